// File: doc/BRIEF.md
# Dual Programmable Interval Timer

This block holds two independent 32-bit up-counters. Each counter has a count value, a limit value and a two-bit control value, and software reaches all of them through a plain register bus: an address, write data, a write strobe, a read strobe and combinational read data. On every cycle in which a counter is allowed to run, it either steps up by one or, if it already equals its limit, goes back to zero. When its interrupt-enable bit is set, that return to zero also raises a level interrupt for that counter.

One control bit ties counting to the processor's run state. When this bit is set and the halt input is high, the count holds its value. A write of any value to a counter's control register acknowledges that counter's pending interrupt. Typical use is one counter as a periodic or one-shot event source that is re-armed from its interrupt handler, and the other as a free-running timestamp with the limit left at all ones.

Top module: `duo_interval_timer`

## Requirements
- R1: After reset both counts and both control registers read 0, both limits read 0xFFFFFFFF and both interrupt lines are low. Counting starts on the first clock edge after reset is released.
- R2: Registers are mapped at fixed addresses. Timer 0 uses 0x021 for the count, 0x022 for the control and 0x023 for the limit. Timer 1 uses 0x100 for the count, 0x101 for the control and 0x102 for the limit. A write with the strobe high stores the data, and a read returns the stored value.
- R3: On a running cycle, a count equal to its limit becomes 0 at the next edge. Any other count becomes count+1.
- R4: Control bit 0 is interrupt enable. When it is 1, the edge at which the count goes from its limit back to 0 also sets that timer's interrupt line.
- R5: With control bit 0 at 0, reaching the limit wraps the count but leaves the interrupt line unchanged.
- R6: Control bit 1 is run-only. While it is 1 and the halt input is high, the count holds. With bit 1 at 0, or with the halt input low, the counter runs.
- R7: A write of any data to a timer's control register clears that timer's pending interrupt at that edge. Control reads return the stored bits in positions 1:0 and zeros above them.
- R8: A pending interrupt stays high until a control write or reset clears it, even if the limit is reached again.
- R9: If a control write and an enabled limit match fall in the same cycle, the interrupt is pending after that edge.
- R10: A count write loads the written value at that edge. It takes priority over the increment or wrap in that cycle.
- R11: Read data is 0 when the read strobe is low or the address is unmapped. Writes to unmapped addresses change nothing.
- R12: The two timers share no state. Counting, writes and acknowledges on one timer leave the other's registers and interrupt unchanged.
- R13: With the limit at 0xFFFFFFFF the count steps from 0xFFFFFFFE to 0xFFFFFFFF and then to 0, giving a monotonic free-running timestamp.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| aux_addr | input | 12 | Register address |
| aux_wdata | input | 32 | Write data |
| aux_wr | input | 1 | Write strobe, one write per high cycle |
| aux_rd | input | 1 | Read strobe that gates the read data |
| cpu_halted | input | 1 | High while the processor is halted |
| aux_rdata | output | 32 | Combinational read data |
| irq | output | 2 | Level interrupt, bit n for timer n |

## Verification
A wrong pending flag appears on the interrupt pin in the cycle right after the faulty edge, so the bench compares both interrupt lines against a behavioural model after every edge. A wrong count, limit or control value only shows when it is read, or later when a limit match comes early or late. For this reason the bench reads the registers often and keeps limits small, so that a bad count turns into a wrong interrupt within a few cycles. The same-cycle acknowledge-and-match race, the halt gating and the all-ones wrap are each forced on purpose with cycle-exact expected values.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int IVT_DW   = 32;
  localparam int IVT_NTMR = 2;
  localparam int IVT_NREG = 3;
  // register offsets from a timer's base address
  localparam int OFS_COUNT = 0;
  localparam int OFS_CTRL  = 1;
  localparam int OFS_LIMIT = 2;
  localparam int IVT_CTLW  = 2;

  typedef struct packed {
    logic run_only;  // bit 1
    logic irq_en;    // bit 0
  } ivt_ctrl_t;

  // next count of a running timer
  function automatic logic [IVT_DW-1:0] ivt_advance(logic [IVT_DW-1:0] cur,
                                                    logic [IVT_DW-1:0] lim);
    return (cur == lim) ? '0 : cur + IVT_DW'(1);
  endfunction

  // timer may count this cycle
  function automatic logic ivt_may_run(ivt_ctrl_t c, logic halted);
    return !(c.run_only && halted);
  endfunction
endpackage

// File: rtl/ivt_regdec.sv
module ivt_regdec
  import ivt_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [IVT_NTMR-1:0][ADDR_W-1:0] BASES = '0
) (
  input  logic [ADDR_W-1:0]                 addr,
  output logic [IVT_NTMR-1:0][IVT_NREG-1:0] sel
);
  for (genvar t = 0; t < IVT_NTMR; t++) begin : g_tmr
    for (genvar r = 0; r < IVT_NREG; r++) begin : g_reg
      assign sel[t][r] = (addr == BASES[t] + ADDR_W'(r));
    end
  end
endmodule

// File: rtl/ivt_channel.sv
module ivt_channel
  import ivt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halted,
  input  logic [IVT_DW-1:0] wdata,
  input  logic              wr_cnt,
  input  logic              wr_ctl,
  input  logic              wr_lim,
  output logic [IVT_DW-1:0] cnt_q,
  output logic [IVT_DW-1:0] lim_q,
  output logic [IVT_CTLW-1:0] ctl_bits,
  output logic              irq
);
  ivt_ctrl_t ctl_q;
  logic      pend_q;

  // named internal events
  logic stall;     // count frozen by halt gating
  logic hit_evt;   // running cycle with count at limit
  logic set_evt;   // interrupt raise in this cycle

  assign stall   = !ivt_may_run(ctl_q, halted);
  assign hit_evt = !stall && (cnt_q == lim_q);
  assign set_evt = hit_evt && ctl_q.irq_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lim_q  <= '1;
      ctl_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (wr_cnt)      cnt_q <= wdata;
      else if (!stall) cnt_q <= ivt_advance(cnt_q, lim_q);
      if (wr_lim) lim_q <= wdata;
      if (wr_ctl) ctl_q <= ivt_ctrl_t'(wdata[IVT_CTLW-1:0]);
      if (set_evt)     pend_q <= 1'b1;
      else if (wr_ctl) pend_q <= 1'b0;
    end
  end

  assign ctl_bits = ctl_q;
  assign irq      = pend_q;

  assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt && !wr_cnt |=> cnt_q == '0);
  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !stall && !hit_evt && !wr_cnt |=> cnt_q == $past(cnt_q) + IVT_DW'(1));
  assert_raise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt && ctl_q.irq_en |=> irq);
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stall && !wr_cnt |=> $stable(cnt_q));
  assert_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl && !set_evt |=> !irq);
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !wr_ctl |=> irq);
  assert_race_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl && set_evt |=> irq);
  assert_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> cnt_q == $past(wdata));
endmodule

// File: rtl/ivt_rdmux.sv
module ivt_rdmux
  import ivt_pkg::*;
(
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  rd,
  input  logic [IVT_NTMR-1:0][IVT_NREG-1:0]     sel,
  input  logic [IVT_NTMR-1:0][IVT_DW-1:0]       cnt_v,
  input  logic [IVT_NTMR-1:0][IVT_DW-1:0]       lim_v,
  input  logic [IVT_NTMR-1:0][IVT_CTLW-1:0]     ctl_v,
  output logic [IVT_DW-1:0]                     rdata
);
  logic any_sel;
  assign any_sel = |sel;

  always_comb begin
    rdata = '0;
    if (rd) begin
      for (int t = 0; t < IVT_NTMR; t++) begin
        if (sel[t][OFS_COUNT]) rdata = rdata | cnt_v[t];
        if (sel[t][OFS_LIMIT]) rdata = rdata | lim_v[t];
        if (sel[t][OFS_CTRL])  rdata = rdata | IVT_DW'(ctl_v[t]);
      end
    end
  end

  assert_quiet_bus_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd || !any_sel |-> rdata == '0);
endmodule

// File: rtl/duo_interval_timer.sv
module duo_interval_timer
  import ivt_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] T0_BASE = 12'h021,
  parameter logic [ADDR_W-1:0] T1_BASE = 12'h100
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   aux_addr,
  input  logic [IVT_DW-1:0]   aux_wdata,
  input  logic                aux_wr,
  input  logic                aux_rd,
  input  logic                cpu_halted,
  output logic [IVT_DW-1:0]   aux_rdata,
  output logic [IVT_NTMR-1:0] irq
);
  localparam logic [IVT_NTMR-1:0][ADDR_W-1:0] BASES = {T1_BASE, T0_BASE};

  logic [IVT_NTMR-1:0][IVT_NREG-1:0] sel;
  logic [IVT_NTMR-1:0][IVT_DW-1:0]   cnt_v;
  logic [IVT_NTMR-1:0][IVT_DW-1:0]   lim_v;
  logic [IVT_NTMR-1:0][IVT_CTLW-1:0] ctl_v;

  ivt_regdec #(.ADDR_W(ADDR_W), .BASES(BASES)) u_dec (
    .addr(aux_addr),
    .sel (sel)
  );

  for (genvar t = 0; t < IVT_NTMR; t++) begin : g_ch
    ivt_channel u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .halted  (cpu_halted),
      .wdata   (aux_wdata),
      .wr_cnt  (aux_wr && sel[t][OFS_COUNT]),
      .wr_ctl  (aux_wr && sel[t][OFS_CTRL]),
      .wr_lim  (aux_wr && sel[t][OFS_LIMIT]),
      .cnt_q   (cnt_v[t]),
      .lim_q   (lim_v[t]),
      .ctl_bits(ctl_v[t]),
      .irq     (irq[t])
    );
  end

  ivt_rdmux u_rd (
    .clk  (clk),
    .rst_n(rst_n),
    .rd   (aux_rd),
    .sel  (sel),
    .cnt_v(cnt_v),
    .lim_v(lim_v),
    .ctl_v(ctl_v),
    .rdata(aux_rdata)
  );

  assert_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));
endmodule

// File: tb/sim_duo_interval_timer.sv
module sim_duo_interval_timer;
  localparam int AW = 12;
  localparam logic [AW-1:0] A_C0 = 12'h021, A_K0 = 12'h022, A_L0 = 12'h023;
  localparam logic [AW-1:0] A_C1 = 12'h100, A_K1 = 12'h101, A_L1 = 12'h102;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic          rst_n;
  logic [AW-1:0] aux_addr;
  logic [31:0]   aux_wdata;
  logic          aux_wr, aux_rd, cpu_halted;
  logic [31:0]   aux_rdata;
  logic [1:0]    irq;

  int n_chk = 0;
  int n_bad = 0;
  bit halt_r = 1'b0;
  bit done = 1'b0;

  // behavioural model state
  logic [31:0] m_cnt [2];
  logic [31:0] m_lim [2];
  bit m_ie [2];
  bit m_nh [2];
  bit m_pend [2];

  duo_interval_timer u0 (
    .clk(clk), .rst_n(rst_n), .aux_addr(aux_addr), .aux_wdata(aux_wdata),
    .aux_wr(aux_wr), .aux_rd(aux_rd), .cpu_halted(cpu_halted),
    .aux_rdata(aux_rdata), .irq(irq)
  );

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  task automatic report(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] base_of(int t);
    return (t == 0) ? A_C0 : A_C1;
  endfunction

  function automatic logic [31:0] m_read(logic [AW-1:0] a);
    for (int t = 0; t < 2; t++) begin
      if (a == base_of(t))     return m_cnt[t];
      if (a == base_of(t) + 1) return {30'd0, m_nh[t], m_ie[t]};
      if (a == base_of(t) + 2) return m_lim[t];
    end
    return 32'd0;
  endfunction

  task automatic m_step(logic [AW-1:0] a, logic [31:0] d, bit w, bit h);
    for (int t = 0; t < 2; t++) begin
      bit run, hit, ie_before, ctl_wr;
      run       = !(m_nh[t] && h);
      hit       = run && (m_cnt[t] == m_lim[t]);
      ie_before = m_ie[t];
      ctl_wr    = w && (a == base_of(t) + 1);
      if (w && a == base_of(t)) m_cnt[t] = d;
      else if (run)             m_cnt[t] = hit ? 32'd0 : m_cnt[t] + 32'd1;
      if (w && a == base_of(t) + 2) m_lim[t] = d;
      if (ctl_wr) begin m_ie[t] = d[0]; m_nh[t] = d[1]; end
      if (hit && ie_before) m_pend[t] = 1'b1;
      else if (ctl_wr)      m_pend[t] = 1'b0;
    end
  endtask

  // one bus cycle, started at a falling edge
  task automatic cyc(logic [AW-1:0] a, logic [31:0] d, bit w, bit r, string tag);
    aux_addr = a; aux_wdata = d; aux_wr = w; aux_rd = r; cpu_halted = halt_r;
    #1;
    if (r) report({tag, " read"}, aux_rdata, m_read(a));
    else   report({tag, " idle bus R11"}, aux_rdata, 32'd0);
    @(posedge clk); #1;
    m_step(a, d, w, halt_r);
    for (int t = 0; t < 2; t++)
      report({tag, " irq R4"}, {31'd0, irq[t]}, {31'd0, m_pend[t]});
    @(negedge clk);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d, string tag);
    cyc(a, d, 1'b1, 1'b0, tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) cyc(12'h000, 32'd0, 1'b0, 1'b0, tag);
  endtask

  task automatic rd_hard(logic [AW-1:0] a, logic [31:0] exp, string tag);
    aux_addr = a; aux_wr = 1'b0; aux_rd = 1'b1; cpu_halted = halt_r;
    #1;
    report(tag, aux_rdata, exp);
    cyc(a, 32'd0, 1'b0, 1'b1, tag);
  endtask

  task automatic irq_hard(int t, bit exp, string tag);
    report(tag, {31'd0, irq[t]}, {31'd0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; aux_addr = '0; aux_wdata = '0; aux_wr = 0; aux_rd = 0; cpu_halted = 0;
    for (int t = 0; t < 2; t++) begin
      m_cnt[t] = 0; m_lim[t] = 32'hFFFF_FFFF; m_ie[t] = 0; m_nh[t] = 0; m_pend[t] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state (counts advance one per read cycle)
    irq_hard(0, 1'b0, "R1 irq0");
    irq_hard(1, 1'b0, "R1 irq1");
    rd_hard(A_C0, 32'd0, "R1 count0");
    rd_hard(A_K0, 32'd0, "R1 ctrl0");
    rd_hard(A_L0, 32'hFFFF_FFFF, "R1 limit0");
    rd_hard(A_K1, 32'd0, "R1 ctrl1");
    rd_hard(A_L1, 32'hFFFF_FFFF, "R1 limit1");
    rd_hard(A_C1, 32'd5, "R1 count1");

    // R2 map and readback
    wr(A_L0, 32'd5, "R2");
    wr(A_L1, 32'd7, "R2");
    rd_hard(A_L0, 32'd5, "R2 limit0");
    rd_hard(A_L1, 32'd7, "R2 limit1");
    wr(A_K0, 32'hFFFF_FFFB, "R7");
    rd_hard(A_K0, 32'd3, "R7 ctrl bits only");
    wr(A_K0, 32'd0, "R2");
    wr(A_L1, 32'hFFFF_FFFF, "R2");

    // R10 count load
    wr(A_C0, 32'd2, "R10");
    rd_hard(A_C0, 32'd2, "R10 loaded");

    // R3/R4 wrap and raise
    wr(A_K0, 32'd1, "R4");
    wr(A_C0, 32'd3, "R4");
    idle(2, "R3");
    irq_hard(0, 1'b0, "R4 before limit");
    idle(1, "R3");
    irq_hard(0, 1'b1, "R4 raised at wrap");
    rd_hard(A_C0, 32'd0, "R3 wrapped to zero");

    // R8 stays pending through a second match
    idle(6, "R8");
    irq_hard(0, 1'b1, "R8 sticky");

    // R7 acknowledge with arbitrary data
    wr(A_C0, 32'd0, "R7");
    wr(A_K0, 32'hA5A5_A5A5, "R7");
    irq_hard(0, 1'b0, "R7 cleared");

    // R9 acknowledge racing a match
    wr(A_K0, 32'd1, "R9");
    wr(A_C0, 32'd5, "R9");
    idle(1, "R9");
    irq_hard(0, 1'b1, "R9 pending");
    wr(A_C0, 32'd5, "R9");
    wr(A_K0, 32'd1, "R9");
    irq_hard(0, 1'b1, "R9 match wins");
    wr(A_K0, 32'd0, "R9");
    irq_hard(0, 1'b0, "R9 later ack");

    // R5 no interrupt when disabled
    wr(A_C0, 32'd5, "R5");
    idle(1, "R5");
    irq_hard(0, 1'b0, "R5 no irq");
    rd_hard(A_C0, 32'd0, "R5 still wraps");

    // R6 halt gating
    wr(A_K0, 32'd2, "R6");
    halt_r = 1'b1;
    wr(A_C0, 32'd1, "R6");
    idle(3, "R6");
    rd_hard(A_C0, 32'd1, "R6 held");
    wr(A_C1, 32'd10, "R6");
    idle(2, "R6");
    rd_hard(A_C1, 32'd12, "R6 ungated runs");
    halt_r = 1'b0;
    idle(2, "R6");
    rd_hard(A_C0, 32'd3, "R6 resumes");

    // R13 free-running wrap at all ones
    wr(A_C1, 32'hFFFF_FFFE, "R13");
    idle(1, "R13");
    rd_hard(A_C1, 32'hFFFF_FFFF, "R13 top");
    rd_hard(A_C1, 32'd0, "R13 wrap");
    irq_hard(1, 1'b0, "R13 no irq");

    // R12 independence
    wr(A_K0, 32'd1, "R12");
    wr(A_C0, 32'd5, "R12");
    idle(1, "R12");
    irq_hard(0, 1'b1, "R12 t0 pending");
    wr(A_K1, 32'd1, "R12");
    irq_hard(0, 1'b1, "R12 t1 ack leaves t0");
    irq_hard(1, 1'b0, "R12 t1 idle");
    rd_hard(A_L0, 32'd5, "R12 limit0 kept");

    // R11 unmapped and gated reads, unmapped writes
    rd_hard(12'h024, 32'd0, "R11 0x024");
    rd_hard(12'h103, 32'd0, "R11 0x103");
    rd_hard(12'h020, 32'd0, "R11 0x020");
    wr(12'h024, 32'd1, "R11");
    wr(12'h0FF, 32'd1, "R11");
    rd_hard(A_L0, 32'd5, "R11 unmapped write ignored");
    cyc(A_L0, 32'd0, 1'b0, 1'b0, "R11 strobe low");

    // mixed traffic compared against the model
    wr(A_L0, 32'd6, "R3");
    wr(A_L1, 32'd4, "R3");
    for (int i = 0; i < 1500; i++) begin
      logic [AW-1:0] a;
      logic [31:0] d;
      int pick;
      pick = $urandom % 8;
      case (pick)
        0: a = A_C0; 1: a = A_K0; 2: a = A_L0; 3: a = A_C1;
        4: a = A_K1; 5: a = A_L1; 6: a = 12'h024; default: a = 12'h000;
      endcase
      d = $urandom % 9;
      halt_r = ($urandom % 3) == 0;
      cyc(a, d, ($urandom % 5) == 0, ($urandom % 2) == 0, "R12 mixed");
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule